// File: doc/BRIEF.md
# Alignment-Based DMA Segment Splitter

This block takes one buffer request and turns it into a short list of transfer descriptors. A request is a start address and a byte length. The rule behind the split is that the transfer hardware can only start a direct segment on a 64-byte boundary. When a buffer does not fit that rule, its unaligned edges are handed off as bounce pieces. Another agent copies those pieces through staging memory. Only the aligned body is read in place.

A request enters through a valid/ready handshake. In the following cycles the block emits one, two or three segments through a second valid/ready handshake, one per cycle while the consumer is ready. The segments come out in address order. Each segment carries its address, its length, a flag that selects bounce or direct, and a marker on the final segment of the request. The block takes no new request until every segment of the current one has been taken. The block produces descriptors only and never moves data.

Top module: `asplit_top`

## Requirements
- R1: Directly after reset, `seg_valid` is 0 and `req_ready` is 1.
- R2: A request that starts off a 64-byte boundary and still contains at least one whole aligned 64-byte block first emits a head segment. The head segment has `seg_bounce`=1, the start address, and a length equal to the distance up to the next 64-byte boundary.
- R3: The middle segment of a split request has `seg_bounce`=0. It starts on a 64-byte boundary, and its length is the largest multiple of 64 that fits between the end of the head and the end of the buffer.
- R4: The bytes after the middle segment, if there are any, leave as one tail segment with `seg_bounce`=1. When the buffer ends on a 64-byte boundary, no tail segment is emitted.
- R5: A request of nonzero length that contains no whole aligned 64-byte block is emitted as exactly one segment with `seg_bounce`=1. That segment covers the whole buffer.
- R6: Segments leave in ascending address order. Each segment starts where the one before it ended, and the lengths add up to the request length.
- R7: `seg_last`=1 on the final segment of a request and 0 on every other segment.
- R8: While `seg_valid`=1 and `seg_ready`=0, the presented segment and all of its fields stay unchanged.
- R9: `req_ready` is 0 while any segment of the current request is still pending, and it returns to 1 in the cycle after the last segment is taken.
- R10: A request of length zero is accepted and produces no segment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Buffer start byte address |
| req_len | input | 16 | Buffer length in bytes |
| seg_valid | output | 1 | Segment present |
| seg_ready | input | 1 | Consumer takes the segment |
| seg_addr | output | 32 | Segment start byte address |
| seg_len | output | 16 | Segment length in bytes |
| seg_bounce | output | 1 | 1 = stage through bounce memory, 0 = direct |
| seg_last | output | 1 | Final segment of the request |

## Verification
The hardest case to reach is the boundary between the single-segment and split forms. A misaligned buffer whose end lands a few bytes short of, exactly on, or just past the first full aligned block decides whether one bounce segment or a head and a middle come out. Random addresses with uniformly drawn lengths rarely hit these points. The directed cases therefore place the end exactly at the head boundary, at the head boundary plus 64, and one byte to either side. Random requests with a 30 percent stall rate on `seg_ready` then check that held segments stay unchanged between hand-offs.

// File: rtl/asplit_pkg.sv
package asplit_pkg;

    localparam int ADDR_W   = 32;
    localparam int LEN_W    = 16;
    localparam int ALIGN_LG = 6;
    localparam int ALIGN_B  = 1 << ALIGN_LG;
    localparam int NSEG     = 3;

    localparam int SLOT_HEAD = 0;
    localparam int SLOT_MID  = 1;
    localparam int SLOT_TAIL = 2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              bounce;
    } seg_t;

    typedef struct packed {
        logic [NSEG-1:0]  live;
        seg_t [NSEG-1:0]  seg;
    } plan_t;

    // Turn one buffer into up to three slots: head, middle, tail.
    function automatic plan_t split_plan(input logic [ADDR_W-1:0] a,
                                         input logic [LEN_W-1:0]  n);
        plan_t                p;
        logic [ALIGN_LG-1:0]  off;
        logic [LEN_W-1:0]     gap, head, rest, mid, tail;
        p    = '0;
        off  = a[ALIGN_LG-1:0];
        gap  = (off == '0) ? '0 : (LEN_W'(ALIGN_B) - LEN_W'(off));
        head = (gap > n) ? n : gap;
        rest = n - head;
        mid  = rest & ~LEN_W'(ALIGN_B - 1);
        tail = rest - mid;
        if (n != '0) begin
            if (mid == '0) begin
                p.live[SLOT_HEAD] = 1'b1;
                p.seg[SLOT_HEAD]  = '{addr: a, len: n, bounce: 1'b1};
            end else begin
                p.live[SLOT_HEAD] = (head != '0);
                p.live[SLOT_MID]  = 1'b1;
                p.live[SLOT_TAIL] = (tail != '0);
                p.seg[SLOT_HEAD]  = '{addr: a, len: head, bounce: 1'b1};
                p.seg[SLOT_MID]   = '{addr: a + ADDR_W'(head), len: mid, bounce: 1'b0};
                p.seg[SLOT_TAIL]  = '{addr: a + ADDR_W'(head) + ADDR_W'(mid),
                                      len: tail, bounce: 1'b1};
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/asplit_plan.sv
module asplit_plan
    import asplit_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output plan_t             plan
);
    always_comb begin
        plan = split_plan(addr, len);
    end
endmodule

// File: rtl/asplit_issue.sv
module asplit_issue
    import asplit_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  plan_t plan_in,
    input  logic  out_ready,
    output logic  busy,
    output logic  out_valid,
    output seg_t  out_seg,
    output logic  out_last
);
    logic [NSEG-1:0] live_q;
    logic [NSEG-1:0] pick;
    seg_t [NSEG-1:0] slot_q;

    // Lowest pending slot is the next in address order.
    always_comb begin
        pick = live_q & (~live_q + NSEG'(1));
    end

    generate
        if (NSEG > 1) begin : g_mux
            always_comb begin
                out_seg = '0;
                for (int i = 0; i < NSEG; i++) begin
                    if (pick[i]) out_seg = slot_q[i];
                end
            end
        end else begin : g_single
            always_comb out_seg = slot_q[0];
        end
    endgenerate

    always_comb begin
        out_valid = |live_q;
        busy      = out_valid;
        out_last  = ((live_q & ~pick) == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
        end else if (load) begin
            live_q <= plan_in.live;
        end else if (out_valid && out_ready) begin
            live_q <= live_q & ~pick;
        end
    end

    always_ff @(posedge clk) begin
        if (load) slot_q <= plan_in.seg;
    end
endmodule

// File: rtl/asplit_top.sv
module asplit_top
    import asplit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              seg_valid,
    input  logic              seg_ready,
    output logic [ADDR_W-1:0] seg_addr,
    output logic [LEN_W-1:0]  seg_len,
    output logic              seg_bounce,
    output logic              seg_last
);
    plan_t plan;
    seg_t  cur;
    logic  busy;
    logic  load;

    asplit_plan u_plan (
        .addr (req_addr),
        .len  (req_len),
        .plan (plan)
    );

    always_comb begin
        req_ready = !busy;
        load      = req_valid && req_ready;
    end

    asplit_issue u_issue (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .plan_in   (plan),
        .out_ready (seg_ready),
        .busy      (busy),
        .out_valid (seg_valid),
        .out_seg   (cur),
        .out_last  (seg_last)
    );

    always_comb begin
        seg_addr   = cur.addr;
        seg_len    = cur.len;
        seg_bounce = cur.bounce;
    end
endmodule

// File: rtl/asplit_checker.sv
module asplit_checker
    import asplit_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              seg_valid,
    input logic              seg_ready,
    input logic [ADDR_W-1:0] seg_addr,
    input logic [LEN_W-1:0]  seg_len,
    input logic              seg_bounce,
    input logic              seg_last
);
    logic fire;
    assign fire = seg_valid && seg_ready;

    assert_direct_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        seg_valid && !seg_bounce |->
            (seg_addr[ALIGN_LG-1:0] == '0) && (seg_len[ALIGN_LG-1:0] == '0));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) &&
            $stable(seg_len) && $stable(seg_bounce) && $stable(seg_last));

    assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        seg_valid |-> !req_ready);

    assert_contiguous_R6: assert property (@(posedge clk) disable iff (rst)
        fire && !seg_last |=>
            seg_valid && (seg_addr == $past(seg_addr) + ADDR_W'($past(seg_len))));

    assert_head_then_direct_R2: assert property (@(posedge clk) disable iff (rst)
        fire && !seg_last && seg_bounce |=> seg_valid && !seg_bounce);

    assert_nonempty_R4: assert property (@(posedge clk) disable iff (rst)
        seg_valid |-> seg_len != '0);
endmodule

bind asplit_top asplit_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .seg_valid  (seg_valid),
    .seg_ready  (seg_ready),
    .seg_addr   (seg_addr),
    .seg_len    (seg_len),
    .seg_bounce (seg_bounce),
    .seg_last   (seg_last)
);

// File: tb/asplit_top_bench.sv
module asplit_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        seg_valid;
    logic        seg_ready = 1'b0;
    logic [31:0] seg_addr;
    logic [15:0] seg_len;
    logic        seg_bounce;
    logic        seg_last;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    longint exp_a [3];
    longint exp_l [3];
    bit     exp_b [3];
    string  exp_t [3];
    int     exp_n;

    asplit_top u_asplit_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .seg_valid(seg_valid),
        .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
        .seg_bounce(seg_bounce), .seg_last(seg_last)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input longint a, input longint l, input bit b, input string t);
        exp_a[exp_n] = a; exp_l[exp_n] = l; exp_b[exp_n] = b; exp_t[exp_n] = t;
        exp_n++;
    endtask

    // Expected split, worked out from aligned block edges.
    task automatic model(input longint a, input longint n);
        longint lo, hi;
        exp_n = 0;
        if (n == 0) return;
        lo = ((a + 63) / 64) * 64;
        hi = ((a + n) / 64) * 64;
        if (hi > lo) begin
            if (lo > a) push(a, lo - a, 1'b1, "R2");
            push(lo, hi - lo, 1'b0, "R3");
            if (a + n > hi) push(hi, a + n - hi, 1'b1, "R4");
        end else begin
            push(a, n, 1'b1, "R5");
        end
    endtask

    task automatic run_req(input longint a, input longint n, input int stall);
        int     idx = 0;
        int     guard = 0;
        longint sum = 0;
        bit     held = 0;
        longint h_a = 0, h_l = 0;
        bit     h_b = 0, h_last = 0;
        model(a, n);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'(a); req_len = 16'(n);
        #1;
        chk(req_ready == 1'b1, "R9 ready when idle", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        while (idx < exp_n && guard < 400) begin
            seg_ready = (($urandom % 100) >= stall);
            #1;
            if (held) begin
                chk(seg_valid && seg_addr == h_a[31:0] && seg_len == h_l[15:0] &&
                    seg_bounce == h_b && seg_last == h_last,
                    "R8 held segment changed", seg_addr, h_a);
                held = 0;
            end
            chk(seg_valid == 1'b1, "R6 segment missing", seg_valid, 1);
            if (idx == 0) chk(req_ready == 1'b0, "R9 ready while pending", req_ready, 0);
            if (seg_valid && seg_ready) begin
                chk(seg_addr == exp_a[idx][31:0], {exp_t[idx], " addr"}, seg_addr, exp_a[idx]);
                chk(seg_len == exp_l[idx][15:0], {exp_t[idx], " len"}, seg_len, exp_l[idx]);
                chk(seg_bounce == exp_b[idx], {exp_t[idx], " bounce"}, seg_bounce, exp_b[idx]);
                chk(seg_last == (idx == exp_n - 1), "R7 last flag", seg_last, idx == exp_n - 1);
                sum += seg_len;
                idx++;
            end else if (seg_valid) begin
                held = 1; h_a = seg_addr; h_l = seg_len; h_b = seg_bounce; h_last = seg_last;
            end
            @(negedge clk);
            guard++;
        end
        seg_ready = 1'b0;
        #1;
        if (exp_n == 0) begin
            chk(seg_valid == 1'b0, "R10 zero length emitted", seg_valid, 0);
        end else begin
            chk(sum == n, "R6 length sum", sum, n);
            chk(seg_valid == 1'b0, "R4 extra segment", seg_valid, 0);
        end
        chk(req_ready == 1'b1, "R9 ready after last", req_ready, 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0A11));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(seg_valid == 1'b0, "R1 seg_valid after reset", seg_valid, 0);
        chk(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);

        run_req(64'h1000, 64, 0);     // aligned single direct
        run_req(64'h1000, 200, 0);    // direct + tail (R4)
        run_req(64'h1000, 256, 0);    // ends on boundary: no tail (R4)
        run_req(64'h100A, 54, 0);     // ends at head boundary: single bounce (R5)
        run_req(64'h100A, 117, 0);    // one byte short of a block (R5)
        run_req(64'h100A, 118, 0);    // head + one block (R2)
        run_req(64'h100A, 119, 0);    // head + block + 1-byte tail
        run_req(64'h100A, 200, 40);   // all three pieces, stalled
        run_req(64'h2000, 30, 0);     // aligned short (R5)
        run_req(64'h203F, 1000, 50);  // one-byte head
        run_req(64'h3005, 0, 0);      // zero length (R10)
        run_req(64'h3005, 100, 0);    // misaligned, no block (R5)

        for (int i = 0; i < 300; i++) begin
            longint a, n;
            a = longint'($urandom & 32'h7FFF_FFFF);
            n = longint'($urandom % 600);
            if ((i % 7) == 0) a = a & ~longint'(63);
            run_req(a, n, 30);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule